// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block runs a chain of transfer descriptors that sit in memory and drives a simple copy engine once for each descriptor. A one-cycle start request supplies the address of the first entry. The sequencer reads the entry one 32-bit word at a time through a single-word request/response port. It then decodes the entry's two-bit control code. For entries that move data, it presents source, destination and byte length on the engine's command port together with a one-cycle go pulse. It waits for the engine's completion before it moves on.

Each entry is three words when the address width is 32 bits or less. Word 0 holds the control code in bits 31:30 and the source byte address in bits 29:0. Word 1 holds the interrupt-enable bit in bit 31, a zero bit in bit 30, and the destination byte address in bits 29:0. Word 2 holds the byte length. When the address width is above 32 bits, the source and destination each take two words, low word first, with the code and interrupt bit at the top of the high word. In that case the entry is five words long. The control codes are: 00 transfer and continue, 01 skip, 10 jump to the table whose address is in the source field, and 11 transfer and end the chain.

While the chain runs, the sequencer reports busy and shows the address of the current entry. It pulses an interrupt on completions that ask for one. It stops on an abort request. It stops with an error flag on a failed fetch or on a failed copy.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset, busy, errFlag, abortFlag, irq, chainDone, rdReq and cmdGo are all low.
- R2: When the block is idle with errFlag low, a startReq makes busy high at the next edge. The first word fetch then goes to startAddr with its two low bits cleared, and curAddr shows that address.
- R3: Each request fetches one word, at curAddr plus 4 times the word index. In the 32-bit format an entry is three words, with the code in word0[31:30], the source in word0[29:0], the interrupt enable in word1[31], the destination in word1[29:0] and the length in word2.
- R4: Code 00 issues one cmdGo carrying the entry's source, destination and length. After engDone, the next entry is fetched from the current address plus 12.
- R5: Code 01 issues no command, and the next entry is fetched from the current address plus 12.
- R6: Code 10 issues no command, and the next entry is fetched from the source field with its two low bits cleared.
- R7: Code 11 issues its command. At the edge that samples engDone, busy falls and chainDone pulses for one cycle.
- R8: irq pulses for one cycle after a successful completion of an entry whose interrupt-enable bit is set, and after completion of the last entry.
- R9: abortReq while busy makes busy low and abortFlag high at the next edge, with no further fetch or command. If a completion arrives in the same cycle, the abort takes priority: there is no irq and no chainDone. The next accepted start clears abortFlag.
- R10: A fetch answered with rdErr, or a completion with engErr, sets errFlag and drops busy with no irq and no chainDone.
- R11: While errFlag is high, startReq is ignored. errClr while idle clears errFlag.
- R12: A startReq while busy is ignored and leaves the running chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse |
| startAddr | input | ADDR_W | First entry address |
| abortReq | input | 1 | Abort request |
| errClr | input | 1 | Clears the error flag while idle |
| rdReq | output | 1 | One-cycle word read request |
| rdAddr | output | ADDR_W | Word read address |
| rdAck | input | 1 | Read response valid |
| rdData | input | 32 | Read response word |
| rdErr | input | 1 | Read response failed |
| cmdGo | output | 1 | One-cycle copy start |
| cmdSrc | output | ADDR_W | Copy source byte address |
| cmdDst | output | ADDR_W | Copy destination byte address |
| cmdLen | output | 32 | Copy byte length |
| engDone | input | 1 | Copy finished |
| engErr | input | 1 | Copy failed, valid with engDone |
| busy | output | 1 | Chain in progress |
| errFlag | output | 1 | Chain ended on an error |
| abortFlag | output | 1 | Chain was aborted |
| irq | output | 1 | One-cycle interrupt pulse |
| chainDone | output | 1 | One-cycle end-of-chain pulse |
| curAddr | output | ADDR_W | Current entry address |

## Verification
An abort request and the copy engine's completion can land in the same cycle. When that happens, the sequencer must choose between finishing the entry, with an interrupt and possibly the end of the chain, and stopping. The engine stub in the bench can raise abortReq on the very cycle it raises engDone. The run is judged correct when abortFlag is set, busy has dropped, and no irq or chainDone pulse appears, even though the entry had its interrupt bit set.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  typedef enum logic [1:0] {
    FL_NEXT = 2'b00,
    FL_SKIP = 2'b01,
    FL_JUMP = 2'b10,
    FL_LAST = 2'b11
  } entryCode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_DEC, ST_RUN
  } seqState_e;

  typedef struct packed {
    logic loadStart;
    logic clrIdx;
    logic capWord;
    logic stepSeq;
    logic jumpTbl;
  } dpStrobe_t;
endpackage

// File: rtl/desc_chain_dp.sv
module desc_chain_dp
  import desc_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [31:0]       rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] cmdSrc,
  output logic [ADDR_W-1:0] cmdDst,
  output logic [31:0]       cmdLen,
  output logic              lastWord,
  output entryCode_e        code,
  output logic              intEn
);
  localparam bit WIDE        = ADDR_W > 32;
  localparam int NWORDS      = WIDE ? 5 : 3;
  localparam int IDX_W       = $clog2(NWORDS + 1);
  localparam int ENTRY_BYTES = 4 * NWORDS;
  localparam int FIELD_W     = WIDE ? 62 : 30;

  logic [31:0]       wordQ [NWORDS];
  logic [IDX_W-1:0]  idx;
  logic [FIELD_W-1:0] srcField, dstField;
  logic [ADDR_W-1:0] alignMask;

  assign alignMask = ~ADDR_W'(3);

  // one capture register per descriptor word
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk)
      if (strobe.capWord && idx == IDX_W'(w)) wordQ[w] <= rdData;
  end

  // field layout depends on the entry format
  if (WIDE) begin : g_wide
    assign code     = entryCode_e'(wordQ[1][31:30]);
    assign srcField = {wordQ[1][29:0], wordQ[0]};
    assign intEn    = wordQ[3][31];
    assign dstField = {wordQ[3][29:0], wordQ[2]};
    assign cmdLen   = wordQ[4];
  end else begin : g_narrow
    assign code     = entryCode_e'(wordQ[0][31:30]);
    assign srcField = wordQ[0][29:0];
    assign intEn    = wordQ[1][31];
    assign dstField = wordQ[1][29:0];
    assign cmdLen   = wordQ[2];
  end

  assign cmdSrc   = ADDR_W'(srcField);
  assign cmdDst   = ADDR_W'(dstField);
  assign rdAddr   = curAddr + ADDR_W'({idx, 2'b00});
  assign lastWord = idx == IDX_W'(NWORDS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      idx     <= '0;
    end else begin
      if (strobe.loadStart)    curAddr <= startAddr & alignMask;
      else if (strobe.jumpTbl) curAddr <= cmdSrc & alignMask;
      else if (strobe.stepSeq) curAddr <= curAddr + ADDR_W'(ENTRY_BYTES);
      if (strobe.clrIdx)       idx <= '0;
      else if (strobe.capWord) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl
  import desc_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       abortReq,
  input  logic       errClr,
  input  logic       rdAck,
  input  logic       rdErr,
  input  logic       engDone,
  input  logic       engErr,
  input  logic       lastWord,
  input  entryCode_e code,
  input  logic       intEn,
  output dpStrobe_t  strobe,
  output logic       rdReq,
  output logic       cmdGo,
  output logic       busy,
  output logic       errFlag,
  output logic       abortFlag,
  output logic       irq,
  output logic       chainDone
);
  seqState_e state;
  logic abortHit;

  assign abortHit = busy && abortReq;

  always_comb begin
    strobe = '0;
    if (!abortHit) begin
      case (state)
        ST_IDLE: if (startReq && !errFlag) begin
          strobe.loadStart = 1'b1;
          strobe.clrIdx    = 1'b1;
        end
        ST_WAIT: strobe.capWord = rdAck && !rdErr;
        ST_DEC: if (code == FL_SKIP) begin
          strobe.stepSeq = 1'b1;
          strobe.clrIdx  = 1'b1;
        end else if (code == FL_JUMP) begin
          strobe.jumpTbl = 1'b1;
          strobe.clrIdx  = 1'b1;
        end
        ST_RUN: if (engDone && !engErr && code != FL_LAST) begin
          strobe.stepSeq = 1'b1;
          strobe.clrIdx  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      errFlag   <= 1'b0;
      abortFlag <= 1'b0;
      rdReq     <= 1'b0;
      cmdGo     <= 1'b0;
      irq       <= 1'b0;
      chainDone <= 1'b0;
    end else begin
      rdReq     <= 1'b0;
      cmdGo     <= 1'b0;
      irq       <= 1'b0;
      chainDone <= 1'b0;
      if (abortHit) begin
        state     <= ST_IDLE;
        busy      <= 1'b0;
        abortFlag <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (errClr) errFlag <= 1'b0;
            if (startReq && !errFlag) begin
              busy      <= 1'b1;
              abortFlag <= 1'b0;
              state     <= ST_REQ;
            end
          end
          ST_REQ: begin
            rdReq <= 1'b1;
            state <= ST_WAIT;
          end
          ST_WAIT: if (rdAck) begin
            if (rdErr) begin
              errFlag <= 1'b1;
              busy    <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              state <= lastWord ? ST_DEC : ST_REQ;
            end
          end
          ST_DEC: begin
            if (code == FL_NEXT || code == FL_LAST) begin
              cmdGo <= 1'b1;
              state <= ST_RUN;
            end else begin
              state <= ST_REQ;
            end
          end
          ST_RUN: if (engDone) begin
            if (engErr) begin
              errFlag <= 1'b1;
              busy    <= 1'b0;
              state   <= ST_IDLE;
            end else begin
              irq <= intEn || code == FL_LAST;
              if (code == FL_LAST) begin
                busy      <= 1'b0;
                chainDone <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                state <= ST_REQ;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import desc_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              abortReq,
  input  logic              errClr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [31:0]       rdData,
  input  logic              rdErr,
  output logic              cmdGo,
  output logic [ADDR_W-1:0] cmdSrc,
  output logic [ADDR_W-1:0] cmdDst,
  output logic [31:0]       cmdLen,
  input  logic              engDone,
  input  logic              engErr,
  output logic              busy,
  output logic              errFlag,
  output logic              abortFlag,
  output logic              irq,
  output logic              chainDone,
  output logic [ADDR_W-1:0] curAddr
);
  dpStrobe_t  strobe;
  entryCode_e code;
  logic       lastWord, intEn;

  desc_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .errClr(errClr), .rdAck(rdAck), .rdErr(rdErr), .engDone(engDone),
    .engErr(engErr), .lastWord(lastWord), .code(code), .intEn(intEn),
    .strobe(strobe), .rdReq(rdReq), .cmdGo(cmdGo), .busy(busy),
    .errFlag(errFlag), .abortFlag(abortFlag), .irq(irq),
    .chainDone(chainDone)
  );

  desc_chain_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .rdData(rdData), .curAddr(curAddr), .rdAddr(rdAddr), .cmdSrc(cmdSrc),
    .cmdDst(cmdDst), .cmdLen(cmdLen), .lastWord(lastWord), .code(code),
    .intEn(intEn)
  );
endmodule

// File: rtl/desc_chain_chk.sv
module desc_chain_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic abortReq,
  input logic rdAck,
  input logic rdErr,
  input logic rdReq,
  input logic cmdGo,
  input logic busy,
  input logic errFlag,
  input logic abortFlag,
  input logic irq,
  input logic chainDone
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startReq && !errFlag |=> busy);

  // R11
  err_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startReq && errFlag |=> !busy);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && abortReq |=> !busy && abortFlag && !irq && !chainDone);

  // R4
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdGo |-> busy && !rdReq);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainDone |-> !busy && !errFlag);

  // R10
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && rdAck && rdErr && !abortReq |=> errFlag && !busy);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

bind desc_chain_seq desc_chain_chk u_chk (.*);

// File: tb/desc_chain_seq_tb.sv
`timescale 1ns/1ps
module desc_chain_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, abortTask = 1'b0, abortAuto = 1'b0, errClr = 1'b0;
  logic [31:0] startAddr = '0;
  logic rdReq, rdAck = 1'b0, rdErr = 1'b0;
  logic [31:0] rdAddr, rdData = '0;
  logic cmdGo, engDone = 1'b0, engErr = 1'b0;
  logic [31:0] cmdSrc, cmdDst, cmdLen, curAddr;
  logic busy, errFlag, abortFlag, irq, chainDone;
  logic abortReq;
  assign abortReq = abortTask | abortAuto;

  always #4 clk = ~clk;

  desc_chain_seq #(.ADDR_W(32)) u_dut (.*);

  int nChk = 0, nFail = 0;
  logic [31:0] mem [1024];

  // bench environment knobs
  int  engDelay = 2;
  bit  engErrArm = 0, abortOnDone = 0, rdErrArm = 0;
  logic [31:0] rdErrAddr = '0;

  // logs, written only by the monitors below
  int cmdCnt = 0, irqCnt = 0, doneCnt = 0, rdCnt = 0;
  logic [31:0] logSrc [256], logDst [256], logLen [256], rdLog [1024];

  int memWait = 0, engWait = 0;
  logic [31:0] pendAddr = '0;

  always @(negedge clk) begin
    rdAck = 1'b0;
    rdErr = 1'b0;
    if (rdReq) begin
      pendAddr = rdAddr;
      memWait  = 1 + int'($urandom % 3);
      rdLog[rdCnt % 1024] = rdAddr;
      rdCnt++;
    end
    if (memWait > 0) begin
      memWait--;
      if (memWait == 0) begin
        rdAck  = 1'b1;
        rdData = mem[(pendAddr >> 2) & 1023];
        rdErr  = rdErrArm && pendAddr == rdErrAddr;
      end
    end
  end

  always @(negedge clk) begin
    engDone   = 1'b0;
    engErr    = 1'b0;
    abortAuto = 1'b0;
    if (cmdGo) begin
      logSrc[cmdCnt % 256] = cmdSrc;
      logDst[cmdCnt % 256] = cmdDst;
      logLen[cmdCnt % 256] = cmdLen;
      cmdCnt++;
      engWait = engDelay + 1;
    end
    if (engWait > 0) begin
      engWait--;
      if (engWait == 0) begin
        engDone   = 1'b1;
        engErr    = engErrArm;
        abortAuto = abortOnDone;
      end
    end
    if (irq) irqCnt++;
    if (chainDone) doneCnt++;
  end

  task automatic chkEq(input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic putDesc(input logic [31:0] a, input logic [1:0] c,
                         input logic [31:0] src, input bit ie,
                         input logic [31:0] dst, input logic [31:0] len);
    mem[(a >> 2) & 1023]       = {c, src[29:0]};
    mem[((a >> 2) + 1) & 1023] = {ie, 1'b0, dst[29:0]};
    mem[((a >> 2) + 2) & 1023] = len;
  endtask

  // reference walk of the chain in memory
  logic [31:0] expSrc [64], expDst [64], expLen [64];
  int expN, expIrq;
  task automatic walkModel(input logic [31:0] start);
    logic [31:0] a, w0, w1;
    expN = 0;
    expIrq = 0;
    a = start & ~32'd3;
    for (int s = 0; s < 64; s++) begin
      w0 = mem[(a >> 2) & 1023];
      w1 = mem[((a >> 2) + 1) & 1023];
      if (w0[31:30] == 2'b01) a = a + 12;
      else if (w0[31:30] == 2'b10) a = {2'b00, w0[29:0]} & ~32'd3;
      else begin
        expSrc[expN] = {2'b00, w0[29:0]};
        expDst[expN] = {2'b00, w1[29:0]};
        expLen[expN] = mem[((a >> 2) + 2) & 1023];
        expN++;
        if (w1[31] || w0[31:30] == 2'b11) expIrq++;
        if (w0[31:30] == 2'b11) break;
        a = a + 12;
      end
    end
  endtask

  task automatic pulseStart(input logic [31:0] sa);
    @(negedge clk);
    startAddr = sa;
    startReq  = 1'b1;
    @(negedge clk);
    startReq  = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkRun(input string req, input int cBase, input int iBase,
                          input int dBase, input int expDone);
    chkEq(req, "command count", cmdCnt - cBase, expN);
    for (int k = 0; k < expN; k++) begin
      chkEq(req, "cmd src", logSrc[(cBase + k) % 256], expSrc[k]);
      chkEq(req, "cmd dst", logDst[(cBase + k) % 256], expDst[k]);
      chkEq(req, "cmd len", logLen[(cBase + k) % 256], expLen[k]);
    end
    chkEq(req, "irq count", irqCnt - iBase, expIrq);
    chkEq(req, "chainDone count", doneCnt - dBase, expDone);
    chkEq(req, "busy after run", busy, 0);
  endtask

  initial begin
    int cB, iB, dB, rB;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chkEq("R1", "idle outputs",
          {busy, errFlag, abortFlag, irq, chainDone, rdReq, cmdGo}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed chain with all four codes: next, skip, jump, next, last
    putDesc(32'h100, 2'b00, 32'h1000, 1, 32'h2000, 32'd64);
    putDesc(32'h10C, 2'b01, 32'h1ABC, 1, 32'h2ABC, 32'd99);
    putDesc(32'h118, 2'b10, 32'h200, 0, 32'h0, 32'd0);
    putDesc(32'h200, 2'b00, 32'h1100, 0, 32'h2100, 32'd32);
    putDesc(32'h20C, 2'b11, 32'h1200, 0, 32'h2200, 32'd8);
    expN = 3; expIrq = 2;
    expSrc[0] = 32'h1000; expDst[0] = 32'h2000; expLen[0] = 64;
    expSrc[1] = 32'h1100; expDst[1] = 32'h2100; expLen[1] = 32;
    expSrc[2] = 32'h1200; expDst[2] = 32'h2200; expLen[2] = 8;
    cB = cmdCnt; iB = irqCnt; dB = doneCnt; rB = rdCnt;
    engDelay = 3;
    pulseStart(32'h102);
    chkEq("R2", "busy after start", busy, 1);
    chkEq("R2", "curAddr aligned", curAddr, 32'h100);
    // R12 second start during the run
    repeat (4) @(negedge clk);
    pulseStart(32'h300);
    waitIdle();
    checkRun("R4 R5 R7 R8 R12", cB, iB, dB, 1);
    chkEq("R3", "fetch count", rdCnt - rB, 15);
    chkEq("R2", "first fetch addr", rdLog[rB % 1024], 32'h100);
    chkEq("R3", "second word addr", rdLog[(rB + 1) % 1024], 32'h104);
    chkEq("R4", "next entry addr", rdLog[(rB + 3) % 1024], 32'h10C);
    chkEq("R5", "after skip addr", rdLog[(rB + 6) % 1024], 32'h118);
    chkEq("R6", "after jump addr", rdLog[(rB + 9) % 1024], 32'h200);

    // Random chains checked against the reference walk
    for (int it = 0; it < 8; it++) begin
      logic [31:0] a;
      int n, r;
      a = 32'h40 * (it % 4);
      n = 2 + int'($urandom % 7);
      for (int e = 0; e < n; e++) begin
        r = int'($urandom % 4);
        if (e == n - 1) r = 3;
        else if (r == 3) r = 0;
        if (r == 2) begin
          putDesc(a, 2'b10, a + 32'h100 + ($urandom % 4), 0, 0, 0);
          a = a + 32'h100;
        end else begin
          putDesc(a, r[1:0], $urandom & 32'h3FFF_FFFF, bit'($urandom % 2),
                  $urandom & 32'h3FFF_FFFF, $urandom);
          a = a + 12;
        end
      end
      engDelay = int'($urandom % 6);
      walkModel(32'h40 * (it % 4));
      cB = cmdCnt; iB = irqCnt; dB = doneCnt;
      pulseStart(32'h40 * (it % 4));
      waitIdle();
      checkRun("R4 R6 R8 random", cB, iB, dB, 1);
    end

    // R9 abort while the engine is running
    putDesc(32'h800, 2'b00, 32'h10, 1, 32'h20, 32'd4);
    putDesc(32'h80C, 2'b11, 32'h30, 0, 32'h40, 32'd4);
    engDelay = 200;
    cB = cmdCnt;
    pulseStart(32'h800);
    for (int i = 0; i < 100 && cmdCnt == cB; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    abortTask = 1'b1;
    @(negedge clk);
    abortTask = 1'b0;
    chkEq("R9", "busy after abort", busy, 0);
    chkEq("R9", "abortFlag set", abortFlag, 1);
    rB = rdCnt; iB = irqCnt; dB = doneCnt;
    repeat (260) @(negedge clk);
    chkEq("R9", "no command after abort", cmdCnt - cB, 1);
    chkEq("R9", "no fetch after abort", rdCnt - rB, 0);
    chkEq("R9", "no irq after abort", irqCnt - iB, 0);
    engDelay = 2;
    walkModel(32'h800);
    cB = cmdCnt; iB = irqCnt; dB = doneCnt;
    pulseStart(32'h800);
    chkEq("R9", "abortFlag cleared by start", abortFlag, 0);
    waitIdle();
    checkRun("R9 restart", cB, iB, dB, 1);

    // R9 abort in the same cycle as the completion
    putDesc(32'h900, 2'b11, 32'h50, 1, 32'h60, 32'd12);
    abortOnDone = 1;
    engDelay = 3;
    cB = cmdCnt; iB = irqCnt; dB = doneCnt;
    pulseStart(32'h900);
    waitIdle();
    abortOnDone = 0;
    chkEq("R9", "same-cycle cmd count", cmdCnt - cB, 1);
    chkEq("R9", "same-cycle irq", irqCnt - iB, 0);
    chkEq("R9", "same-cycle chainDone", doneCnt - dB, 0);
    chkEq("R9", "same-cycle abortFlag", abortFlag, 1);

    // R10 fetch error on the second word
    rdErrArm = 1;
    rdErrAddr = 32'h904;
    cB = cmdCnt; iB = irqCnt; dB = doneCnt;
    pulseStart(32'h900);
    waitIdle();
    rdErrArm = 0;
    chkEq("R10", "errFlag on fetch error", errFlag, 1);
    chkEq("R10", "no command on fetch error", cmdCnt - cB, 0);
    chkEq("R10", "no done on fetch error", doneCnt - dB, 0);

    // R11 start ignored while the error is held, then cleared
    rB = rdCnt;
    pulseStart(32'h900);
    repeat (3) @(negedge clk);
    chkEq("R11", "busy while error held", busy, 0);
    chkEq("R11", "no fetch while error held", rdCnt - rB, 0);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    chkEq("R11", "errFlag cleared", errFlag, 0);

    // R10 engine error: no irq even with interrupt enable
    engErrArm = 1;
    cB = cmdCnt; iB = irqCnt; dB = doneCnt;
    pulseStart(32'h900);
    waitIdle();
    engErrArm = 0;
    chkEq("R10", "errFlag on engine error", errFlag, 1);
    chkEq("R10", "no irq on engine error", irqCnt - iB, 0);
    chkEq("R10", "no done on engine error", doneCnt - dB, 0);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    walkModel(32'h900);
    cB = cmdCnt; iB = irqCnt; dB = doneCnt;
    pulseStart(32'h900);
    waitIdle();
    checkRun("R11 after clear", cB, iB, dB, 1);

    summary();
  end
endmodule